// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block turns an 8-bit parallel byte into an asynchronous serial frame. It runs from a clock at sixteen times the bit rate, so every serial bit lasts sixteen clock cycles. A host writes a byte by pulling an active-low load strobe low. The byte first lands in a holding register and then moves into a shift register, which drives the serial line.

Because there are two registers, the host can queue one byte while the previous one is still being sent. When the current frame ends, the queued byte follows with no idle gap. Each frame is fixed: a low start bit, eight data bits with the least significant bit first, an odd-parity bit, and two high stop bits. Two flags tell the host whether the holding register is free and whether the whole transmitter is drained.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_o` is 1 and both `hold_empty_o` and `shift_empty_o` are 1.
- R2: A frame is 12 bit periods long. In order it holds a 0 start bit, eight data bits, a parity bit and two 1 stop bits.
- R3: The data bits go out least significant bit first: frame bit k (k = 1..8) carries `data_i[k-1]`.
- R4: The parity bit is 0 when the byte has an odd number of ones and 1 when it has an even number.
- R5: A 1-to-0 transition of `load_ni` captures `data_i`, and `hold_empty_o` is 0 in the next cycle. When the shifter is idle, the start bit appears one cycle later and `hold_empty_o` returns to 1. Keeping `load_ni` low starts no further frame.
- R6: Every serial bit holds its value for exactly 16 clock cycles.
- R7: A byte loaded during a frame keeps `hold_empty_o` at 0 until that frame's last stop bit ends. Its start bit then follows in the very next cycle, and `hold_empty_o` returns to 1.
- R8: `shift_empty_o` is 1 only when the shifter is idle and the holding register is empty.
- R9: A load while the holding register is full replaces the stored byte. Only the last byte loaded is sent, and no flag reports this.
- R10: Asserting `rst_ni` during a frame stops it at once. `tx_o` returns to 1 and a pending byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at 16 times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| load_ni | input | 1 | Active-low load strobe; the falling edge loads the byte |
| data_i | input | 8 | Byte to transmit |
| tx_o | output | 1 | Serial output, high when idle |
| hold_empty_o | output | 1 | Holding register is free |
| shift_empty_o | output | 1 | Shifter idle and holding register free |

## Verification
The hardest case to reach is the end of a frame while a byte is waiting, because the hand-off happens in a single cycle. The stimulus loads a second byte a few cycles into a frame and lets the first frame run to its last stop-bit cycle. It then checks that the next start bit follows with no idle cycle and that the holding flag rises at that moment. The overwrite case uses the same setup with a third load before the frame ends, and the bench confirms that only the newest byte appears on the line.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;
endpackage

// File: rtl/uart_strobe_fall.sv
module uart_strobe_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_ni;
  end

  assign fall_o = strobe_q & ~strobe_ni;

  // R5
  fall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/uart_hold_reg.sv
module uart_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end

  // R7
  write_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);

  // R9
  overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> (data_o == $past(data_i)));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int STOP_BITS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              last_o
);
  localparam int FRAME_W = DATA_W + 2 + STOP_BITS;
  localparam int TICK_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W   = $clog2(FRAME_W);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [TICK_W-1:0]  tick_q;
  logic [BIT_W-1:0]   bit_q;
  logic               tick_end;

  // odd parity: bit set when the byte has an even count of ones
  assign frame_d  = {{STOP_BITS{1'b1}}, ~(^data_i), data_i, 1'b0};
  assign tick_end = (tick_q == TICK_W'(OVERSAMPLE - 1));
  assign busy_o   = (state_q == TX_SEND);
  assign last_o   = busy_o && tick_end && (bit_q == BIT_W'(FRAME_W - 1));
  assign tx_o     = busy_o ? frame_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
    end else if (start_i) begin
      state_q <= TX_SEND;
      frame_q <= frame_d;
      tick_q  <= '0;
      bit_q   <= '0;
    end else if (busy_o) begin
      if (tick_end) begin
        tick_q <= '0;
        if (last_o) begin
          state_q <= TX_IDLE;
        end else begin
          bit_q   <= bit_q + 1'b1;
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  // R6
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_q != '0) |-> $stable(tx_o));

  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !tx_o);

  // R2
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bit_q >= BIT_W'(FRAME_W - STOP_BITS)) |-> tx_o);
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int STOP_BITS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              hold_empty_o,
  output logic              shift_empty_o
);
  logic              load_fall;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              last;

  uart_strobe_fall u_fall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (load_ni),
    .fall_o    (load_fall)
  );

  uart_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (load_fall),
    .data_i (data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  // hand-off on idle, or in the last cycle of the final stop bit
  assign take = hold_full & (~busy | last);

  uart_tx_shifter #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE),
    .STOP_BITS  (STOP_BITS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .data_i  (hold_data),
    .tx_o    (tx_o),
    .busy_o  (busy),
    .last_o  (last)
  );

  assign hold_empty_o  = ~hold_full;
  assign shift_empty_o = ~busy & ~hold_full;

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);

  // R8
  drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> (hold_empty_o && tx_o));

  // R7
  handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hold_full && !load_fall) |=> (!tx_o && hold_empty_o));

  // R5
  load_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fall |=> !hold_empty_o);
endmodule

// File: tb/uart_dbuf_tx_tb_top.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       load_ni;
  logic [7:0] data_i;
  logic       tx_o, hold_empty_o, shift_empty_o;

  always #2.5 clk_i = ~clk_i;

  uart_dbuf_tx dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_ni       (load_ni),
    .data_i        (data_i),
    .tx_o          (tx_o),
    .hold_empty_o  (hold_empty_o),
    .shift_empty_o (shift_empty_o)
  );

  // {expected parity (R4), byte}
  localparam logic [8:0] VEC [7] = '{
    {1'b0, 8'h67}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h01},
    {1'b0, 8'h80}, {1'b1, 8'hA5}, {1'b0, 8'hEA}
  };

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // entered at the first cycle of the start bit; leaves one cycle after the frame
  task automatic check_frame(input logic [7:0] d, input logic par, input string tag);
    for (int k = 0; k < 12; k++) begin
      logic e;
      if (k == 0)      e = 1'b0;
      else if (k <= 8) e = d[k-1];
      else if (k == 9) e = par;
      else             e = 1'b1;
      chk($sformatf("R2/R3/R4 %s bit %0d first cycle", tag, k), tx_o, e);
      repeat (15) @(negedge clk_i);
      chk($sformatf("R6 %s bit %0d last cycle", tag, k), tx_o, e);
      @(negedge clk_i);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_ni  = 1'b0;
    load_ni = 1'b1;
    data_i  = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset tx", tx_o, 1);
    chk("R1 reset hold_empty", hold_empty_o, 1);
    chk("R1 reset shift_empty", shift_empty_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle tx after reset", tx_o, 1);

    // table walk
    for (int i = 0; i < 7; i++) begin
      data_i  = VEC[i][7:0];
      load_ni = 1'b0;
      @(negedge clk_i);
      chk("R5 hold_empty low after load", hold_empty_o, 0);
      chk("R8 shift_empty low with byte held", shift_empty_o, 0);
      load_ni = 1'b1;
      @(negedge clk_i);
      chk("R5 hold_empty high after transfer", hold_empty_o, 1);
      chk("R8 shift_empty low while sending", shift_empty_o, 0);
      check_frame(VEC[i][7:0], VEC[i][8], "table");
      chk("R1 idle tx after frame", tx_o, 1);
      chk("R8 shift_empty high when drained", shift_empty_o, 1);
      repeat (4) @(negedge clk_i);
    end

    // R5: strobe held low gives exactly one frame
    data_i  = 8'h3C;
    load_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    data_i = 8'h55;
    check_frame(8'h3C, 1'b1, "R5 held strobe");
    chk("R5 no reload while held low tx", tx_o, 1);
    chk("R5 no reload while held low flag", hold_empty_o, 1);
    repeat (20) @(negedge clk_i);
    chk("R5 still idle", tx_o, 1);
    load_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R7: back-to-back frames
    data_i  = 8'h5A;
    load_ni = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1;
    @(negedge clk_i);
    fork
      check_frame(8'h5A, 1'b1, "R7 first");
      begin
        repeat (3) @(negedge clk_i);
        data_i  = 8'h07;
        load_ni = 1'b0;
        @(negedge clk_i);
        load_ni = 1'b1;
        chk("R7 hold_empty low with queued byte", hold_empty_o, 0);
        chk("R8 shift_empty low with queued byte", shift_empty_o, 0);
        repeat (100) @(negedge clk_i);
        chk("R7 hold_empty still low mid-frame", hold_empty_o, 0);
      end
    join
    chk("R7 hold_empty high at hand-off", hold_empty_o, 1);
    check_frame(8'h07, 1'b0, "R7 second");
    chk("R7 idle after second frame", tx_o, 1);
    repeat (4) @(negedge clk_i);

    // R9: overwrite of a full holding register
    data_i  = 8'h11;
    load_ni = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1;
    @(negedge clk_i);
    fork
      check_frame(8'h11, 1'b1, "R9 first");
      begin
        repeat (3) @(negedge clk_i);
        data_i  = 8'h22;
        load_ni = 1'b0;
        @(negedge clk_i);
        load_ni = 1'b1;
        repeat (25) @(negedge clk_i);
        data_i  = 8'hE0;
        load_ni = 1'b0;
        @(negedge clk_i);
        load_ni = 1'b1;
        chk("R9 hold_empty low after overwrite", hold_empty_o, 0);
      end
    join
    check_frame(8'hE0, 1'b0, "R9 newest byte");
    chk("R9 older byte not sent tx", tx_o, 1);
    chk("R9 older byte not sent flag", hold_empty_o, 1);
    repeat (4) @(negedge clk_i);

    // R10: reset mid-frame with a pending byte
    data_i  = 8'h00;
    load_ni = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    data_i  = 8'hFF;
    load_ni = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    chk("R10 frame running before reset", tx_o, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 tx high in reset", tx_o, 1);
    chk("R10 hold_empty high in reset", hold_empty_o, 1);
    chk("R10 shift_empty high in reset", shift_empty_o, 1);
    rst_ni = 1'b1;
    begin
      logic seen_low = 1'b0;
      for (int c = 0; c < 250; c++) begin
        @(negedge clk_i);
        if (!tx_o) seen_low = 1'b1;
      end
      chk("R10 pending byte discarded", seen_low, 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule